// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block turns a programmed transfer request into a stream of memory segments for a downstream data fetcher. In list mode it reads a table of 8-byte descriptors from memory, starting at the programmed source address. Each descriptor holds a length word followed by an address word. For each descriptor the block emits one segment, made of an address, a length and a final flag. In direct mode it emits exactly one segment, built straight from the source-address and length inputs, and makes no memory reads.

The memory side is a single-outstanding read port. A request holds its address until the memory accepts it, and one response word comes back later with a valid strobe. The downstream side is a valid/ready segment channel. A walk ends after the descriptor whose length word has its end bit set. If the entry limit is reached first, the walk is cut short: that segment is marked final and an error flag is raised. A one-cycle done pulse follows acceptance of the final segment.

Top module: `sgl_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req_valid`, `seg_valid`, `done` and `err_noterm` are all 0.
- R2: With `sg_en`=0, a start produces exactly one segment with address `src_addr[30:0]`, length `src_len[27:0]` and `seg_last`=1, and issues no memory request.
- R3: With `sg_en`=1, descriptor i is fetched with two reads in this order: the length word at `src_addr + 8*i`, then the address word at `src_addr + 8*i + 4`.
- R4: The segment length is bits [27:0] of the length word. Bits [30:28] have no effect.
- R5: The segment address is bits [30:0] of the address word. Bit 31 has no effect.
- R6: A length word with bit 31 set marks the final descriptor. Its segment carries `seg_last`=1, and no further memory reads follow.
- R7: If MAX_ENT descriptors are walked without an end bit, the walk stops. The MAX_ENT-th segment carries `seg_last`=1, and `err_noterm` is 1 in the same cycle as `done`. Otherwise `err_noterm` stays 0.
- R8: `done` is high for exactly one cycle: the cycle after the final segment is accepted.
- R9: While a request or segment is offered but not accepted, it stays asserted with unchanged address, length and flag values.
- R10: A start pulse while `busy` is 1 is ignored. No extra segment or memory read results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (sampled when idle) |
| sg_en | input | 1 | 1 = descriptor list mode, 0 = single direct segment |
| src_addr | input | 32 | List base address, or segment address in direct mode |
| src_len | input | 32 | Segment length in direct mode (bits [27:0] used) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| seg_valid | output | 1 | Segment offered downstream |
| seg_ready | input | 1 | Downstream accepts the segment |
| seg_addr | output | 31 | Segment start address |
| seg_len | output | 28 | Segment length in bytes |
| seg_last | output | 1 | Final segment of this walk |
| done | output | 1 | One-cycle pulse after the final segment is taken |
| err_noterm | output | 1 | Walk ended at the entry limit without an end bit |
| busy | output | 1 | A walk is in progress |

## Verification
A corrupted descriptor index or base register shows up at the next memory request: the address deviates from base + 8*i, so the ordered read log flags it within a single descriptor fetch. A wrong captured length word, or a wrong decode, appears on the very next segment as a bad length or final flag. A stale forced-stop or done state shows up one cycle after the final hand-off, as a missing, extra or mis-flagged done pulse. Stalls on both sides are varied so that a hold violation would change values seen by the scoreboard.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
    localparam int WORD_W      = 32;
    localparam int SEG_AW      = 31;
    localparam int SEG_LW      = 28;
    localparam int END_BIT     = 31;
    localparam int ENTRY_BYTES = 8;
    localparam int ADDR_OFS    = 4;

    typedef struct packed {
        logic [SEG_AW-1:0] addr;
        logic [SEG_LW-1:0] len;
        logic              last;
    } seg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_LEN,
        ST_WAIT_LEN,
        ST_REQ_ADR,
        ST_WAIT_ADR,
        ST_EMIT
    } walk_st_e;

    function automatic logic [SEG_LW-1:0] len_field(input logic [WORD_W-1:0] w);
        return w[SEG_LW-1:0];
    endfunction

    function automatic logic [SEG_AW-1:0] addr_field(input logic [WORD_W-1:0] w);
        return w[SEG_AW-1:0];
    endfunction
endpackage

// File: rtl/sgl_decode.sv
module sgl_decode
    import sgl_pkg::*;
(
    input  logic [WORD_W-1:0] len_word,
    input  logic [WORD_W-1:0] addr_word,
    input  logic              at_limit,
    output seg_t              seg,
    output logic              forced_stop
);
    logic end_mark;
    logic unused_bits;

    assign end_mark    = len_word[END_BIT];
    assign unused_bits = ^{len_word[END_BIT-1:SEG_LW], addr_word[WORD_W-1:SEG_AW]};

    always_comb begin
        seg.addr    = addr_field(addr_word);
        seg.len     = len_field(len_word);
        seg.last    = end_mark | at_limit;
        forced_stop = at_limit & ~end_mark;
    end
endmodule

// File: rtl/sgl_ctrl.sv
module sgl_ctrl
    import sgl_pkg::*;
#(
    parameter int MAX_ENT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sg_en,
    input  logic [WORD_W-1:0] src_addr,
    input  logic [WORD_W-1:0] src_len,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WORD_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic [WORD_W-1:0] len_word,
    output logic              at_limit,
    input  seg_t              dec_seg,
    input  logic              dec_forced,
    output seg_t              seg_o,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic              done,
    output logic              err_noterm,
    output logic              busy
);
    localparam int CNT_W = (MAX_ENT > 1) ? $clog2(MAX_ENT) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_ENT - 1);

    walk_st_e          st_q;
    logic [WORD_W-1:0] base_q;
    logic [WORD_W-1:0] len_word_q;
    logic [CNT_W-1:0]  idx_q;
    seg_t              seg_q;
    logic              forced_q;
    logic              done_q;
    logic              err_q;
    logic              unused_src;

    assign unused_src = ^{src_addr[WORD_W-1:SEG_AW], src_len[WORD_W-1:SEG_LW]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            base_q     <= '0;
            len_word_q <= '0;
            idx_q      <= '0;
            seg_q      <= '0;
            forced_q   <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q    <= '0;
                        base_q   <= src_addr;
                        forced_q <= 1'b0;
                        if (sg_en) begin
                            st_q <= ST_REQ_LEN;
                        end else begin
                            seg_q.addr <= src_addr[SEG_AW-1:0];
                            seg_q.len  <= src_len[SEG_LW-1:0];
                            seg_q.last <= 1'b1;
                            st_q       <= ST_EMIT;
                        end
                    end
                end
                ST_REQ_LEN:  if (mem_req_ready) st_q <= ST_WAIT_LEN;
                ST_WAIT_LEN: begin
                    if (mem_rsp_valid) begin
                        len_word_q <= mem_rsp_data;
                        st_q       <= ST_REQ_ADR;
                    end
                end
                ST_REQ_ADR:  if (mem_req_ready) st_q <= ST_WAIT_ADR;
                ST_WAIT_ADR: begin
                    if (mem_rsp_valid) begin
                        seg_q    <= dec_seg;
                        forced_q <= dec_forced;
                        st_q     <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (seg_ready) begin
                        if (seg_q.last) begin
                            done_q <= 1'b1;
                            err_q  <= forced_q;
                            st_q   <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= ST_REQ_LEN;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_valid = (st_q == ST_REQ_LEN) || (st_q == ST_REQ_ADR);
        mem_req_addr  = base_q + WORD_W'(idx_q) * WORD_W'(ENTRY_BYTES)
                      + ((st_q == ST_REQ_ADR) ? WORD_W'(ADDR_OFS) : '0);
    end

    assign len_word   = len_word_q;
    assign at_limit   = (idx_q == LAST_IDX);
    assign seg_o      = seg_q;
    assign seg_valid  = (st_q == ST_EMIT);
    assign done       = done_q;
    assign err_noterm = err_q;
    assign busy       = (st_q != ST_IDLE);
endmodule

// File: rtl/sgl_walker.sv
module sgl_walker
    import sgl_pkg::*;
#(
    parameter int MAX_ENT = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  sg_en,
    input  logic [WORD_W-1:0]     src_addr,
    input  logic [WORD_W-1:0]     src_len,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [WORD_W-1:0]     mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [WORD_W-1:0]     mem_rsp_data,
    output logic                  seg_valid,
    input  logic                  seg_ready,
    output logic [SEG_AW-1:0]     seg_addr,
    output logic [SEG_LW-1:0]     seg_len,
    output logic                  seg_last,
    output logic                  done,
    output logic                  err_noterm,
    output logic                  busy
);
    logic [WORD_W-1:0] len_word;
    logic              at_limit;
    seg_t              dec_seg;
    logic              dec_forced;
    seg_t              seg_o;

    sgl_decode u_decode (
        .len_word    (len_word),
        .addr_word   (mem_rsp_data),
        .at_limit    (at_limit),
        .seg         (dec_seg),
        .forced_stop (dec_forced)
    );

    sgl_ctrl #(.MAX_ENT(MAX_ENT)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .sg_en         (sg_en),
        .src_addr      (src_addr),
        .src_len       (src_len),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .len_word      (len_word),
        .at_limit      (at_limit),
        .dec_seg       (dec_seg),
        .dec_forced    (dec_forced),
        .seg_o         (seg_o),
        .seg_valid     (seg_valid),
        .seg_ready     (seg_ready),
        .done          (done),
        .err_noterm    (err_noterm),
        .busy          (busy)
    );

    assign seg_addr = seg_o.addr;
    assign seg_len  = seg_o.len;
    assign seg_last = seg_o.last;
endmodule

// File: rtl/sgl_walker_chk.sv
module sgl_walker_chk
    import sgl_pkg::*;
#(
    parameter int MAX_ENT = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [WORD_W-1:0] mem_req_addr,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic [SEG_AW-1:0] seg_addr,
    input logic [SEG_LW-1:0] seg_len,
    input logic              seg_last,
    input logic              done,
    input logic              err_noterm
);
    int unsigned hs_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_cnt <= 0;
        end else if (start && !busy) begin
            hs_cnt <= 0;
        end else if (seg_valid && seg_ready) begin
            hs_cnt <= hs_cnt + 1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req_valid && !seg_valid)); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9

    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && !seg_ready) |=>
            (seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_last))); // R9

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(seg_valid && seg_ready && seg_last)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err_noterm |-> done); // R7

    AST_ENTRY_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && seg_ready) |-> (hs_cnt < MAX_ENT)); // R7
endmodule

bind sgl_walker sgl_walker_chk #(.MAX_ENT(MAX_ENT)) u_chk (.*);

// File: tb/sgl_walker_tb.sv
module sgl_walker_tb;
    localparam int MAX_ENT = 16;

    typedef struct {
        logic [30:0] a;
        logic [27:0] l;
        logic        last;
        logic        err;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        sg_en = 1'b0;
    logic [31:0] src_addr = '0;
    logic [31:0] src_len = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        seg_valid;
    logic        seg_ready = 1'b0;
    logic [30:0] seg_addr;
    logic [27:0] seg_len;
    logic        seg_last;
    logic        done;
    logic        err_noterm;
    logic        busy;

    logic [31:0] mem [256];
    exp_t        exp_q[$];
    logic [31:0] rd_q[$];
    int          checks = 0;
    int          errors = 0;
    int          done_cnt = 0;
    int          cyc = 0;
    int          pend = 0;
    logic [31:0] pend_data = '0;
    bit          exp_done = 0;
    bit          exp_err = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    sgl_walker #(.MAX_ENT(MAX_ENT)) u_dut (
        .clk(clk), .rst(rst), .start(start), .sg_en(sg_en),
        .src_addr(src_addr), .src_len(src_len),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .seg_valid(seg_valid),
        .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
        .seg_last(seg_last), .done(done), .err_noterm(err_noterm),
        .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // memory model: ordered read log plus variable latency
    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pend_data;
            end
        end
        mem_req_ready = ((cyc % 4) != 2);
        if (!rst && mem_req_valid && mem_req_ready) begin
            if (rd_q.size() == 0) begin
                check(1'b0, "R2/R6/R10 unexpected read", 64'(mem_req_addr), 0);
            end else begin
                logic [31:0] e;
                e = rd_q.pop_front();
                check(mem_req_addr == e, "R3 read address", 64'(mem_req_addr), 64'(e));
            end
            pend      = 1 + (cyc % 3);
            pend_data = mem[(mem_req_addr >> 2) & 32'hFF];
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (exp_done || done) begin
                check(done == exp_done, "R8 done pulse", 64'(done), 64'(exp_done));
                if (exp_done)
                    check(err_noterm == exp_err, "R7 err_noterm", 64'(err_noterm), 64'(exp_err));
            end
            if (done) done_cnt++;
            exp_done = 0;
            seg_ready = ((cyc % 3) != 1);
            if (seg_valid && seg_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected segment", 64'(seg_addr), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(seg_addr == e.a, "R5 seg_addr", 64'(seg_addr), 64'(e.a));
                    check(seg_len == e.l, "R4 seg_len", 64'(seg_len), 64'(e.l));
                    check(seg_last == e.last, "R6 seg_last", 64'(seg_last), 64'(e.last));
                    if (e.last) begin
                        exp_done = 1;
                        exp_err  = e.err;
                    end
                end
            end
        end
    end

    task automatic wait_done();
        int d0;
        d0 = done_cnt;
        while (done_cnt == d0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic plain_case(input logic [31:0] a, input logic [31:0] l);
        exp_q.push_back('{a: a[30:0], l: l[27:0], last: 1'b1, err: 1'b0});
        @(negedge clk);
        sg_en = 1'b0; src_addr = a; src_len = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    task automatic sg_case(input logic [31:0] base, input int n, input bit term,
                           input bit poke);
        for (int i = 0; i < n; i++) begin
            logic [31:0] lw, aw, la;
            lw = {term && (i == n - 1), 3'b101, 28'(32'h0ABC000 + i * 32'h1111)};
            aw = {1'b1, 31'(32'h2000_0000 + i * 32'h80)};
            la = base + 32'(i * 8);
            mem[(la >> 2) & 32'hFF]       = lw;
            mem[((la + 4) >> 2) & 32'hFF] = aw;
            rd_q.push_back(la);
            rd_q.push_back(la + 4);
            exp_q.push_back('{a: aw[30:0], l: lw[27:0], last: (i == n - 1),
                              err: (i == n - 1) && !term});
        end
        @(negedge clk);
        sg_en = 1'b1; src_addr = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            sg_en = 1'b0; src_addr = 32'h0000_0F00; src_len = 32'h55; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!busy, "R1 busy", 64'(busy), 0);
        check(!mem_req_valid, "R1 mem_req_valid", 64'(mem_req_valid), 0);
        check(!seg_valid && !done && !err_noterm, "R1 outputs",
              64'({seg_valid, done, err_noterm}), 0);
        // R2: direct mode, upper bits dropped
        plain_case(32'hFFFF_1234, 32'hF123_4567);
        plain_case(32'h0000_0010, 32'h0000_0000);
        // R3..R6: list walks of different lengths
        sg_case(32'h0000_0100, 3, 1'b1, 1'b0);
        sg_case(32'h0000_0040, 1, 1'b1, 1'b0);
        // R7: missing terminator stops at the limit
        sg_case(32'h0000_0200, MAX_ENT, 1'b0, 1'b0);
        // R10: start while busy is ignored
        sg_case(32'h0000_0300, 4, 1'b1, 1'b1);
        check(exp_q.size() == 0, "R6 segments left", 64'(exp_q.size()), 0);
        check(rd_q.size() == 0, "R3 reads left", 64'(rd_q.size()), 0);
        repeat (5) @(negedge clk);
        check(!busy, "R10 idle after walk", 64'(busy), 0);
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end
endmodule